// File: doc/BRIEF.md
# Machine Check Syndrome Capture Unit

This unit sits beside a processor core and gathers the events that raise a machine check. These are error reports tied to the instruction stream, an edge on the non-maskable interrupt pin, and bus-error terminations that arrive out of step with execution. It keeps a syndrome register whose bits tell a handler which kind of event occurred. A fault-address register, guarded by a valid flag, holds the target of an asynchronous bus error. A pair of save/restore registers holds the program counter and machine status from the moment of entry.

When an event is taken while no machine check is in progress, the unit raises a one-cycle request to the core and marks itself busy. Software reads the recorded state and clears it with write-one-to-clear accesses. It may rewrite the saved program counter to step past a faulting instruction that cannot be repaired. A return strobe then hands the saved program counter and status back to the core and ends the busy period.

Top module: `mc_syndrome_unit`

## Requirements
- R1: After reset, `mc_req`, `in_mc`, `fault_addr_valid`, `syndrome`, `fault_addr`, `saved_pc` and `saved_status` are all zero.
- R2: A stream error (`sync_err_valid`=1) is taken whatever the state of the enable bit. `sync_err_kind` 00 (fetch), 01 (load) and 10 (store) map to syndrome bits 0, 1 and 2. Kind 11 has no effect. A taken stream error replaces syndrome bits 3:0 with its own one-hot code.
- R3: An interrupt-pin event is taken on a high-to-low change of `nmi_n` sampled while `nmi_en`=1, whatever the state of the enable bit. It replaces syndrome bits 3:0 with bit 3 alone. Holding the pin low does not retake the event, and with `nmi_en`=0 a falling edge has no effect.
- R4: A bus error (`bus_err_valid`=1) is taken only while `cur_status` bit `ME_BIT` (default 4) is 1. Kinds 00 (instruction read), 01 (data read) and 10 (data write) OR syndrome bit 4, 5 or 6 into the register, leaving the other bits as they are. While the enable bit is 0, or for kind 11, a bus error has no effect.
- R5: A taken bus error loads `fault_addr` and sets `fault_addr_valid` only if the flag was 0. While the flag is 1, `fault_addr` keeps its value. Stream errors and pin events never change either.
- R6: A taken event while `in_mc`=0 makes `mc_req` 1 for exactly the next cycle. On that edge `in_mc` is set and `saved_pc`/`saved_status` load `cur_pc`/`cur_status`. Events taken while `in_mc`=1 update the syndrome and fault address but raise no request and leave the saved registers unchanged.
- R7: A write with `sw_sel`=00 clears each syndrome bit whose `sw_wdata` bit is 1. A write with `sw_sel`=01 and `sw_wdata[0]`=1 clears `fault_addr_valid`. Bits written as 0 are unchanged.
- R8: A write with `sw_sel`=10 loads `sw_wdata` into `saved_pc` on the next edge.
- R9: `rfmc` while `in_mc`=1 gives `restore_valid`=1 in the same cycle, with `restore_pc`=`saved_pc` and `restore_status`=`saved_status`, and clears `in_mc` on the next edge. `rfmc` while `in_mc`=0 gives `restore_valid`=0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | AW | Address of the current instruction |
| cur_status | input | SW | Current machine status; bit ME_BIT enables bus errors |
| sync_err_valid | input | 1 | Stream error report |
| sync_err_kind | input | 2 | Stream error kind: 00 fetch, 01 load, 10 store |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low |
| nmi_en | input | 1 | Interrupt pin signalling enable |
| bus_err_valid | input | 1 | Bus error termination |
| bus_err_kind | input | 2 | Bus error kind: 00 instruction read, 01 data read, 10 data write |
| bus_err_addr | input | AW | Target address of the failed access |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 00 syndrome, 01 valid flag, 10 saved pc |
| sw_wdata | input | AW | Software write data |
| rfmc | input | 1 | Return-from-machine-check strobe |
| mc_req | output | 1 | One-cycle machine check request |
| in_mc | output | 1 | Machine check in progress |
| syndrome | output | 7 | Cause bits |
| fault_addr | output | AW | Captured bus error address |
| fault_addr_valid | output | 1 | Fault address holds a capture |
| saved_pc | output | AW | Saved return address |
| saved_status | output | SW | Saved machine status |
| restore_valid | output | 1 | Restore strobe to the core |
| restore_pc | output | AW | Program counter to restore |
| restore_status | output | SW | Status to restore |

## Verification
A busy flag stuck high in error suppresses every later request, which shows at `mc_req` on the first event after the return. A wrongly cleared flag makes the next nested event raise a second request and overwrite `saved_pc` one cycle later. A valid flag that fails to hold lets a second bus error change `fault_addr` on the edge that follows it. A syndrome merge error shows in the register value one cycle after the event.

// File: rtl/mc_syndrome_unit.sv
`timescale 1ns/1ps
module mc_syndrome_unit #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int ME_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_pc,
  input  logic [SW-1:0] cur_status,
  input  logic          sync_err_valid,
  input  logic [1:0]    sync_err_kind,
  input  logic          nmi_n,
  input  logic          nmi_en,
  input  logic          bus_err_valid,
  input  logic [1:0]    bus_err_kind,
  input  logic [AW-1:0] bus_err_addr,
  input  logic          sw_we,
  input  logic [1:0]    sw_sel,
  input  logic [AW-1:0] sw_wdata,
  input  logic          rfmc,
  output logic          mc_req,
  output logic          in_mc,
  output logic [6:0]    syndrome,
  output logic [AW-1:0] fault_addr,
  output logic          fault_addr_valid,
  output logic [AW-1:0] saved_pc,
  output logic [SW-1:0] saved_status,
  output logic          restore_valid,
  output logic [AW-1:0] restore_pc,
  output logic [SW-1:0] restore_status
);
  logic       nmi_prev;
  logic       sync_take, nmi_fire, async_take, any_take, enter;
  logic [2:0] sync_dec, async_dec;
  logic [6:0] syn_clr;
  logic       valid_clr;

  assign sync_take  = sync_err_valid && (sync_err_kind != 2'b11);
  assign nmi_fire   = nmi_en && nmi_prev && !nmi_n;
  assign async_take = bus_err_valid && (bus_err_kind != 2'b11) && cur_status[ME_BIT];
  assign any_take   = sync_take || nmi_fire || async_take;
  assign enter      = any_take && !in_mc;

  assign sync_dec  = sync_take  ? (3'b001 << sync_err_kind) : 3'b000;
  assign async_dec = async_take ? (3'b001 << bus_err_kind)  : 3'b000;

  assign syn_clr   = (sw_we && sw_sel == 2'b00) ? sw_wdata[6:0] : 7'd0;
  assign valid_clr = sw_we && (sw_sel == 2'b01) && sw_wdata[0];

  assign restore_valid  = rfmc && in_mc;
  assign restore_pc     = saved_pc;
  assign restore_status = saved_status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_prev <= 1'b1;
    else        nmi_prev <= nmi_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syndrome <= '0;
    end else begin
      if (sync_take || nmi_fire) syndrome[3:0] <= {nmi_fire, sync_dec};
      else                       syndrome[3:0] <= syndrome[3:0] & ~syn_clr[3:0];
      syndrome[6:4] <= (syndrome[6:4] & ~syn_clr[6:4]) | async_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr       <= '0;
      fault_addr_valid <= 1'b0;
    end else if (async_take && !fault_addr_valid) begin
      fault_addr       <= bus_err_addr;
      fault_addr_valid <= 1'b1;
    end else if (valid_clr) begin
      fault_addr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_req       <= 1'b0;
      in_mc        <= 1'b0;
      saved_pc     <= '0;
      saved_status <= '0;
    end else begin
      mc_req <= enter;
      if (enter) begin
        in_mc        <= 1'b1;
        saved_pc     <= cur_pc;
        saved_status <= cur_status;
      end else begin
        if (restore_valid) in_mc <= 1'b0;
        if (sw_we && sw_sel == 2'b10) saved_pc <= sw_wdata;
      end
    end
  end

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_req |=> !mc_req);
  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_req |-> in_mc);
  p_nested_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mc && !restore_valid) |=> (!mc_req && $stable(saved_status)));
  p_sync_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err_valid && sync_err_kind != 2'b11 && !in_mc) |=> mc_req);
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_addr_valid && !valid_clr) |=> (fault_addr_valid && $stable(fault_addr)));
  p_async_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_valid && !cur_status[ME_BIT] && !fault_addr_valid) |=> !fault_addr_valid);
  p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_valid && !any_take) |=> !in_mc);
endmodule

// File: tb/mc_syndrome_unit_tb.sv
`timescale 1ns/1ps
module mc_syndrome_unit_tb_top;
  localparam int AW = 32, SW = 8;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cur_pc = 0, bus_err_addr = 0, sw_wdata = 0;
  logic [SW-1:0] cur_status = 0;
  logic sync_err_valid = 0, nmi_n = 1, nmi_en = 0, bus_err_valid = 0, sw_we = 0, rfmc = 0;
  logic [1:0] sync_err_kind = 0, bus_err_kind = 0, sw_sel = 0;
  logic mc_req, in_mc, fault_addr_valid, restore_valid;
  logic [6:0] syndrome;
  logic [AW-1:0] fault_addr, saved_pc, restore_pc;
  logic [SW-1:0] saved_status, restore_status;
  int n_run = 0, n_fail = 0;

  mc_syndrome_unit dut_i (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [AW-1:0] d);
    sw_we = 1; sw_sel = sel; sw_wdata = d;
    step();
    sw_we = 0; sw_wdata = 0;
  endtask

  task automatic do_return(input logic [AW-1:0] epc, input logic [SW-1:0] est);
    rfmc = 1; #1;
    chk("R9 restore_valid", restore_valid, 1);
    chk("R9 restore_pc", restore_pc, epc);
    chk("R9 restore_status", restore_status, est);
    step(); rfmc = 0;
    chk("R9 in_mc cleared", in_mc, 0);
    sw_write(2'b00, 32'h7f);
    sw_write(2'b01, 32'h1);
  endtask

  task automatic t_reset();
    chk("R1 mc_req", mc_req, 0);
    chk("R1 in_mc", in_mc, 0);
    chk("R1 syndrome", syndrome, 0);
    chk("R1 valid", fault_addr_valid, 0);
    chk("R1 fault_addr", fault_addr, 0);
    chk("R1 saved_pc", saved_pc, 0);
    chk("R1 saved_status", saved_status, 0);
  endtask

  task automatic t_sync();
    sync_err_valid = 1; sync_err_kind = 2'b11; step(); sync_err_valid = 0;
    chk("R2 kind 11 no req", mc_req, 0);
    chk("R2 kind 11 no syndrome", syndrome, 0);
    cur_status = 8'h00; cur_pc = 32'h100;
    sync_err_valid = 1; sync_err_kind = 2'b01; step(); sync_err_valid = 0;
    chk("R2 load taken with enable off", mc_req, 1);
    chk("R6 in_mc set", in_mc, 1);
    chk("R2 load syndrome", syndrome, 7'h02);
    chk("R6 saved_pc", saved_pc, 32'h100);
    chk("R5 sync leaves valid", fault_addr_valid, 0);
    step();
    chk("R6 single pulse", mc_req, 0);
    do_return(32'h100, 8'h00);
  endtask

  task automatic t_async();
    cur_status = 8'h00; bus_err_valid = 1; bus_err_kind = 2'b01; bus_err_addr = 32'h1000;
    step(); bus_err_valid = 0;
    chk("R4 gated no req", mc_req, 0);
    chk("R4 gated no syndrome", syndrome, 0);
    chk("R4 gated no capture", fault_addr_valid, 0);
    cur_status = 8'h10; cur_pc = 32'h200;
    bus_err_valid = 1; bus_err_kind = 2'b10; bus_err_addr = 32'h2000;
    step(); bus_err_valid = 0;
    chk("R4 write error req", mc_req, 1);
    chk("R4 write error syndrome", syndrome, 7'h40);
    chk("R5 capture valid", fault_addr_valid, 1);
    chk("R5 capture addr", fault_addr, 32'h2000);
    cur_pc = 32'h300; cur_status = 8'h11;
    bus_err_valid = 1; bus_err_kind = 2'b00; bus_err_addr = 32'h3000;
    step(); bus_err_valid = 0;
    chk("R4 accumulate", syndrome, 7'h50);
    chk("R5 hold addr", fault_addr, 32'h2000);
    chk("R6 nested no req", mc_req, 0);
    chk("R6 nested saved_pc kept", saved_pc, 32'h200);
    sw_write(2'b01, 32'h0);
    chk("R7 zero write keeps valid", fault_addr_valid, 1);
    sw_write(2'b01, 32'h1);
    chk("R7 valid cleared", fault_addr_valid, 0);
    chk("R7 syndrome untouched", syndrome, 7'h50);
    bus_err_valid = 1; bus_err_kind = 2'b01; bus_err_addr = 32'h4000;
    step(); bus_err_valid = 0;
    chk("R5 recapture addr", fault_addr, 32'h4000);
    chk("R4 three bits", syndrome, 7'h70);
    sw_write(2'b00, 32'h10);
    chk("R7 partial clear", syndrome, 7'h60);
    sw_write(2'b00, 32'h0);
    chk("R7 zero write keeps syndrome", syndrome, 7'h60);
    do_return(32'h200, 8'h10);
  endtask

  task automatic t_nmi();
    cur_status = 8'h00; cur_pc = 32'h400;
    nmi_en = 0; nmi_n = 0; step();
    chk("R3 disabled no req", mc_req, 0);
    step();
    chk("R3 disabled no syndrome", syndrome, 0);
    nmi_n = 1; step();
    nmi_en = 1; nmi_n = 0; step();
    chk("R3 edge taken", mc_req, 1);
    chk("R3 syndrome", syndrome, 7'h08);
    chk("R5 nmi leaves valid", fault_addr_valid, 0);
    step();
    chk("R3 held low no retake", mc_req, 0);
    cur_pc = 32'h480;
    sync_err_valid = 1; sync_err_kind = 2'b00; step(); sync_err_valid = 0;
    chk("R2 replace low bits", syndrome, 7'h01);
    chk("R6 saved_pc kept", saved_pc, 32'h400);
    chk("R6 nested no req", mc_req, 0);
    do_return(32'h400, 8'h00);
    nmi_n = 1; nmi_en = 0; step();
  endtask

  task automatic t_edit_pc();
    cur_status = 8'h10; cur_pc = 32'h500;
    sync_err_valid = 1; sync_err_kind = 2'b10; step(); sync_err_valid = 0;
    chk("R2 store syndrome", syndrome, 7'h04);
    chk("R6 saved_status", saved_status, 8'h10);
    sw_write(2'b10, 32'h504);
    chk("R8 saved_pc written", saved_pc, 32'h504);
    do_return(32'h504, 8'h10);
  endtask

  task automatic t_idle_return();
    rfmc = 1; #1;
    chk("R9 idle no restore", restore_valid, 0);
    step(); rfmc = 0;
    chk("R9 idle in_mc", in_mc, 0);
    chk("R9 idle no req", mc_req, 0);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_sync();
    t_async();
    t_nmi();
    t_edit_pc();
    t_idle_return();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule